// File: doc/BRIEF.md
# SPI DMA Request Handshake

This block connects the status side of an SPI data path to a DMA controller. It keeps a transmit-buffer-empty flag and a receive-buffer-full flag. From these flags it raises one DMA request line for each direction. A request is raised only when the module enable and the DMA enable for that direction are both set. When the DMA controller finishes a transfer it pulses a done strobe, and that strobe clears the matching flag with no software access. The request line then falls on the same clock edge that clears the flag. The serial shift engine is not modelled. It appears only as two strobes: one that takes a transmit unit out of the buffer, and one that captures a received unit.

The transmit side tracks a fill level against a slot limit that depends on two settings, FIFO mode and the data unit width. With FIFO mode off there is a single slot, so each request moves exactly one byte or one 16-bit word. With FIFO mode on, the transmit FIFO holds `FIFO_BYTES` bytes. In byte mode that gives `FIFO_BYTES` slots, so one request can be answered by a burst of up to 8 byte writes at the default size. In 16-bit mode it gives `FIFO_BYTES/2` slots, up to 4 word writes.

A write that arrives when no slot is free is dropped, and it sets a sticky overflow bit. Whenever the shift engine removes a unit, the transmit-empty flag is set again, because the buffer has room at that point.

Top module: `spi_dma_handshake`

## Requirements
- R1: After reset, `tx_empty`=1, `rx_full`=0, `tx_req`=0, `rx_req`=0, `tx_overflow`=0 and `tx_level`=0.
- R2: `tx_req` is registered. After each rising edge it equals (`spi_en` AND `tx_dma_en` as sampled at that edge) AND the updated `tx_empty`. If either enable is low, no transmit request is raised.
- R3: A `tx_done` pulse clears `tx_empty` at the next edge, and `tx_req` is low after that same edge. The exception is a `tx_load` that removes a unit in the same cycle; in that case `tx_empty` stays set.
- R4: `rx_req` is registered. After each rising edge it equals (`spi_en` AND `rx_dma_en` as sampled at that edge) AND the updated `rx_full`. A `rx_capture` pulse sets `rx_full`.
- R5: A `rx_done` pulse clears `rx_full` at the next edge, and `rx_req` is low after that same edge. If `rx_capture` arrives in the same cycle, `rx_full` stays set.
- R6: A `rx_done` pulse while `rx_full` is 0 has no effect: `rx_full` and `rx_req` stay 0.
- R7: With `fifo_mode`=0 the transmit buffer holds one unit in either width. The first `tx_wr` makes `tx_level`=1, and a second write is dropped.
- R8: With `fifo_mode`=1 and `word_mode`=0 (8-bit units), 8 writes are accepted (`tx_level`=8) and the 9th is dropped.
- R9: With `fifo_mode`=1 and `word_mode`=1 (16-bit units), 4 writes are accepted (`tx_level`=4) and the 5th is dropped.
- R10: A dropped write leaves `tx_level` unchanged and sets `tx_overflow`, which stays 1 until reset. Acceptance is judged on the level before the cycle, so a write into a full buffer is dropped even when a unit leaves in that same cycle.
- R11: A `tx_load` with `tx_level`>0 decrements the level and sets `tx_empty`. A `tx_load` at level 0 is ignored: the level and `tx_empty` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_en | input | 1 | Module enable, gates both requests |
| tx_dma_en | input | 1 | Transmit DMA enable |
| rx_dma_en | input | 1 | Receive DMA enable |
| fifo_mode | input | 1 | 1 selects the multi-slot transmit FIFO |
| word_mode | input | 1 | 0 = 8-bit units, 1 = 16-bit units |
| tx_wr | input | 1 | DMA writes one unit to the transmit data register |
| tx_load | input | 1 | Shift engine takes one unit from the transmit buffer |
| tx_done | input | 1 | DMA transmit completion strobe |
| rx_capture | input | 1 | Shift engine has completed a received unit |
| rx_done | input | 1 | DMA receive completion strobe |
| tx_req | output | 1 | Transmit DMA request |
| rx_req | output | 1 | Receive DMA request |
| tx_empty | output | 1 | Transmit-buffer-empty flag |
| rx_full | output | 1 | Receive-buffer-full flag |
| tx_overflow | output | 1 | Sticky dropped-write indicator |
| tx_level | output | LVL_W | Transmit units currently held |

## Verification
The hardest cases to reach from the ports are the slot-limit boundaries and the same-cycle collisions on the flags. For the slot limits, each FIFO and width setting starts from a fresh reset and is fed back-to-back writes until one write past capacity. The bench then reads `tx_level` and the sticky overflow bit. For the collisions, done and load (or capture and done) are driven on the same negative edge, so the set-wins rule is tested in one exact cycle. A load at level zero is also driven right after a done, so that an ignored load would show up as a wrongly set empty flag.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;

  typedef enum logic {
    UNIT_BYTE = 1'b0,
    UNIT_WORD = 1'b1
  } unit_w_e;

  // Number of transmit units the buffer may hold in a given mode.
  function automatic int unsigned slot_limit(input logic fifo_on,
                                             input unit_w_e uw,
                                             input int unsigned fifo_bytes);
    if (!fifo_on) return 1;
    if (uw == UNIT_WORD) return fifo_bytes / 2;
    return fifo_bytes;
  endfunction

endpackage

// File: rtl/spi_dma_tx_buf.sv
module spi_dma_tx_buf #(
  parameter int unsigned FIFO_BYTES = 8,
  localparam int unsigned LVL_W = $clog2(FIFO_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fifo_mode,
  input  spi_dma_pkg::unit_w_e  unit_w,
  input  logic                  wr,
  input  logic                  load,
  input  logic                  done,
  output logic [LVL_W-1:0]      level,
  output logic                  empty_flag,
  output logic                  empty_nxt,
  output logic                  overflow
);

  logic [LVL_W-1:0] limit;
  logic             has_room;
  logic             wr_accept;
  logic             wr_drop;
  logic             unit_take;
  logic [LVL_W-1:0] level_nxt;

  assign limit     = LVL_W'(spi_dma_pkg::slot_limit(fifo_mode, unit_w, FIFO_BYTES));
  assign has_room  = level < limit;
  assign wr_accept = wr & has_room;
  assign wr_drop   = wr & ~has_room;
  assign unit_take = load & (level != '0);
  assign level_nxt = level + LVL_W'(wr_accept) - LVL_W'(unit_take);

  // Room appearing wins over a completion in the same cycle.
  always_comb begin
    if (unit_take)  empty_nxt = 1'b1;
    else if (done)  empty_nxt = 1'b0;
    else            empty_nxt = empty_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level      <= '0;
      empty_flag <= 1'b1;
      overflow   <= 1'b0;
    end else begin
      level      <= level_nxt;
      empty_flag <= empty_nxt;
      if (wr_drop) overflow <= 1'b1;
    end
  end

  a_r10_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(FIFO_BYTES));

  a_r10_drop_holds_level: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drop && !unit_take) |=> (level == $past(level)) && overflow);

  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r3_done_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !unit_take) |=> !empty_flag);

  a_r11_take_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
    unit_take |=> empty_flag);

  a_r11_idle_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (load && level == '0 && !wr && !done) |=> (level == '0) && $stable(empty_flag));

endmodule

// File: rtl/spi_dma_rx_flag.sv
module spi_dma_rx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic done,
  output logic full_flag,
  output logic full_nxt
);

  // New data arriving wins over a completion in the same cycle.
  always_comb begin
    if (capture)    full_nxt = 1'b1;
    else if (done)  full_nxt = 1'b0;
    else            full_nxt = full_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_flag <= 1'b0;
    else        full_flag <= full_nxt;
  end

  a_r5_done_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !capture) |=> !full_flag);

  a_r5_capture_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> full_flag);

  a_r6_idle_done_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_flag && !capture) |=> !full_flag);

endmodule

// File: rtl/spi_dma_req_gen.sv
module spi_dma_req_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic flag_nxt,
  output logic req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= gate & flag_nxt;
  end

endmodule

// File: rtl/spi_dma_handshake.sv
module spi_dma_handshake #(
  parameter int unsigned FIFO_BYTES = 8,
  localparam int unsigned LVL_W = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_en,
  input  logic             tx_dma_en,
  input  logic             rx_dma_en,
  input  logic             fifo_mode,
  input  logic             word_mode,
  input  logic             tx_wr,
  input  logic             tx_load,
  input  logic             tx_done,
  input  logic             rx_capture,
  input  logic             rx_done,
  output logic             tx_req,
  output logic             rx_req,
  output logic             tx_empty,
  output logic             rx_full,
  output logic             tx_overflow,
  output logic [LVL_W-1:0] tx_level
);

  spi_dma_pkg::unit_w_e unit_w;
  logic tx_gate;
  logic rx_gate;
  logic tx_empty_nxt;
  logic rx_full_nxt;
  logic past_ok;

  assign unit_w  = spi_dma_pkg::unit_w_e'(word_mode);
  assign tx_gate = spi_en & tx_dma_en;
  assign rx_gate = spi_en & rx_dma_en;

  spi_dma_tx_buf #(.FIFO_BYTES(FIFO_BYTES)) u_tx_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_mode  (fifo_mode),
    .unit_w     (unit_w),
    .wr         (tx_wr),
    .load       (tx_load),
    .done       (tx_done),
    .level      (tx_level),
    .empty_flag (tx_empty),
    .empty_nxt  (tx_empty_nxt),
    .overflow   (tx_overflow)
  );

  spi_dma_rx_flag u_rx_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (rx_capture),
    .done      (rx_done),
    .full_flag (rx_full),
    .full_nxt  (rx_full_nxt)
  );

  spi_dma_req_gen u_tx_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate     (tx_gate),
    .flag_nxt (tx_empty_nxt),
    .req      (tx_req)
  );

  spi_dma_req_gen u_rx_req (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate     (rx_gate),
    .flag_nxt (rx_full_nxt),
    .req      (rx_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r2_tx_req_gating: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (tx_req == ($past(spi_en && tx_dma_en) && tx_empty)));

  a_r4_rx_req_gating: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (rx_req == ($past(spi_en && rx_dma_en) && rx_full)));

  a_r3_tx_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_load) |=> !tx_req);

  a_r5_rx_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_capture) |=> !rx_req);

endmodule

// File: tb/tb_spi_dma_handshake.sv
`timescale 1ns/1ps
module tb_spi_dma_handshake;

  localparam int unsigned FIFO_BYTES = 8;
  localparam int unsigned LVL_W = $clog2(FIFO_BYTES + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_en = 0, tx_dma_en = 0, rx_dma_en = 0, fifo_mode = 0, word_mode = 0;
  logic tx_wr = 0, tx_load = 0, tx_done = 0, rx_capture = 0, rx_done = 0;
  logic tx_req, rx_req, tx_empty, rx_full, tx_overflow;
  logic [LVL_W-1:0] tx_level;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  spi_dma_handshake #(.FIFO_BYTES(FIFO_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .tx_dma_en(tx_dma_en),
    .rx_dma_en(rx_dma_en), .fifo_mode(fifo_mode), .word_mode(word_mode),
    .tx_wr(tx_wr), .tx_load(tx_load), .tx_done(tx_done),
    .rx_capture(rx_capture), .rx_done(rx_done), .tx_req(tx_req),
    .rx_req(rx_req), .tx_empty(tx_empty), .rx_full(rx_full),
    .tx_overflow(tx_overflow), .tx_level(tx_level)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_strobes();
    tx_wr = 0; tx_load = 0; tx_done = 0; rx_capture = 0; rx_done = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    spi_en = 0; tx_dma_en = 0; rx_dma_en = 0; fifo_mode = 0; word_mode = 0;
    clear_strobes();
    step(); step();
    rst_n = 1;
    step();
  endtask

  // R1
  task automatic t_reset_state();
    do_reset();
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_full", rx_full, 0);
    chk("R1 tx_req", tx_req, 0);
    chk("R1 rx_req", rx_req, 0);
    chk("R1 tx_overflow", tx_overflow, 0);
    chk("R1 tx_level", tx_level, 0);
  endtask

  // R2
  task automatic t_tx_gating();
    do_reset();
    spi_en = 1; tx_dma_en = 0; step();
    chk("R2 only spi_en", tx_req, 0);
    spi_en = 0; tx_dma_en = 1; step();
    chk("R2 only tx_dma_en", tx_req, 0);
    spi_en = 1; step();
    chk("R2 both enables", tx_req, 1);
    spi_en = 0; step();
    chk("R2 spi_en dropped", tx_req, 0);
  endtask

  // R3, R11
  task automatic t_tx_done_and_load();
    do_reset();
    spi_en = 1; tx_dma_en = 1; step();
    chk("R3 req before done", tx_req, 1);
    tx_wr = 1; tx_done = 1; step(); clear_strobes();
    chk("R3 empty cleared", tx_empty, 0);
    chk("R3 req dropped", tx_req, 0);
    chk("R7 level after one write", tx_level, 1);
    tx_load = 1; step(); clear_strobes();
    chk("R11 load sets empty", tx_empty, 1);
    chk("R11 load level", tx_level, 0);
    chk("R11 req back", tx_req, 1);
    tx_wr = 1; step(); clear_strobes();
    tx_load = 1; tx_done = 1; step(); clear_strobes();
    chk("R3 load wins over done", tx_empty, 1);
    tx_done = 1; step(); clear_strobes();
    chk("R3 plain done", tx_empty, 0);
    tx_load = 1; step(); clear_strobes();
    chk("R11 idle load empty", tx_empty, 0);
    chk("R11 idle load level", tx_level, 0);
  endtask

  // R7, R8, R9, R10
  task automatic t_capacity(input logic fm, input logic wm, input int cap, input string tag);
    do_reset();
    fifo_mode = fm; word_mode = wm;
    for (int i = 0; i < cap; i++) begin
      tx_wr = 1; step();
    end
    clear_strobes();
    chk({tag, " level at capacity"}, tx_level, cap);
    chk({tag, " no overflow yet"}, tx_overflow, 0);
    tx_wr = 1; step(); clear_strobes();
    chk({tag, " R10 level after drop"}, tx_level, cap);
    chk({tag, " R10 overflow set"}, tx_overflow, 1);
  endtask

  // R10 same-cycle write and load at full, sticky
  task automatic t_full_collision();
    do_reset();
    tx_wr = 1; step();
    tx_wr = 1; tx_load = 1; step(); clear_strobes();
    chk("R10 write dropped with load", tx_level, 0);
    chk("R10 overflow on collision", tx_overflow, 1);
    step(); step();
    chk("R10 overflow sticky", tx_overflow, 1);
  endtask

  // R4, R5, R6
  task automatic t_rx_path();
    do_reset();
    spi_en = 1; rx_dma_en = 1; step();
    chk("R4 no req when empty", rx_req, 0);
    rx_done = 1; step(); clear_strobes();
    chk("R6 idle done full", rx_full, 0);
    chk("R6 idle done req", rx_req, 0);
    rx_capture = 1; step(); clear_strobes();
    chk("R4 capture sets full", rx_full, 1);
    chk("R4 req raised", rx_req, 1);
    rx_done = 1; step(); clear_strobes();
    chk("R5 done clears full", rx_full, 0);
    chk("R5 req dropped", rx_req, 0);
    rx_capture = 1; rx_done = 1; step(); clear_strobes();
    chk("R5 capture wins", rx_full, 1);
    rx_dma_en = 0; step();
    chk("R4 rx_dma_en low", rx_req, 0);
    chk("R4 full kept", rx_full, 1);
  endtask

  initial begin
    t_reset_state();
    t_tx_gating();
    t_tx_done_and_load();
    t_capacity(1'b0, 1'b0, 1, "R7 byte");
    t_capacity(1'b0, 1'b1, 1, "R7 word");
    t_capacity(1'b1, 1'b0, FIFO_BYTES, "R8");
    t_capacity(1'b1, 1'b1, FIFO_BYTES / 2, "R9");
    t_full_collision();
    t_rx_path();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule